// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Controller

This block holds the control-hazard logic for a five-stage in-order pipeline. The stages are fetch, decode, execute, memory and writeback. Branches are resolved in decode, and fetch always runs down the fall-through path. Each cycle the block looks at the instruction in decode. If it is a valid branch, the block reads the comparison outcome and the computed target. From these it drives three outputs: the program-counter source select, the redirect address and a clear line for the fetch/decode pipeline register.

A branch needs a source register to make its decision. If an older instruction that is still too far back in the pipeline will write that register, the block raises a single stall output instead. Stall freezes fetch and decode and puts a bubble into execute. A mode input chooses between two policies for a taken branch. In squash mode the one instruction already fetched behind the branch is cleared. In delay-slot mode that instruction always runs.

Three counters track issued instructions, stall cycles and squashed fetches. From them a pipeline model can confirm its cycles per instruction.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, all three counters read zero.
- R2: If a valid branch in decode is not taken and has no hazard, `pc_sel` is 0, `ifid_flush` is 0 and `stall` is 0 in that same cycle, so the branch costs no cycle.
- R3: If `delay_mode` is 0 and a valid branch is taken with no hazard, then in the same cycle `pc_sel` is 1, `ifid_flush` is 1 and `redirect_pc` equals `id_target`.
- R4: If `delay_mode` is 1, `ifid_flush` is never 1. A taken, hazard-free branch still sets `pc_sel` to 1.
- R5: A branch source counts as pending when three things hold: its use bit is set, its number is not 0, and it matches either `ex_dst` while `ex_wr_en` is 1 or `mem_dst` while `mem_load` is 1. A valid branch with a pending source raises `stall`. Register 0 never causes a stall.
- R6: In a cycle with `stall` high, `pc_sel` and `ifid_flush` are both 0. Once the hazard clears, the branch still held in decode is evaluated again.
- R7: If decode holds no valid branch (`id_valid` is 0 or `id_is_branch` is 0), `stall`, `pc_sel` and `ifid_flush` are all 0.
- R8: `stall_cnt` goes up by one after every cycle with `stall` high. `flush_cnt` goes up by one after every cycle with `ifid_flush` high. `issue_cnt` goes up by one after every cycle with `id_valid` high and `stall` low. The counters wrap at their width.
- R9: Consider a steady taken loop in squash mode made of four instructions: a load of r1, a write of r2, a write of r5, and a branch on r5. Each pass through the loop adds 4 issued, 1 stall and 1 flush, and takes 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| delay_mode | input | 1 | 1 selects one architectural delay slot; 0 selects squash of the younger fetch |
| id_valid | input | 1 | Decode holds a real instruction |
| id_is_branch | input | 1 | The decode instruction is a conditional branch |
| id_taken | input | 1 | Result of the branch comparison |
| id_target | input | AW | Branch target computed in decode |
| id_use_a | input | 1 | The branch reads source A |
| id_src_a | input | RW | Source A register number |
| id_use_b | input | 1 | The branch reads source B |
| id_src_b | input | RW | Source B register number |
| ex_wr_en | input | 1 | The execute-stage instruction writes a register (ALU or load) |
| ex_dst | input | RW | Destination of the execute-stage instruction |
| mem_load | input | 1 | The memory-stage instruction is a load |
| mem_dst | input | RW | Destination of the memory-stage load |
| pc_sel | output | 1 | 1 makes fetch take `redirect_pc` next |
| redirect_pc | output | AW | Address for a taken branch |
| ifid_flush | output | 1 | Turns the fetch/decode register content into a bubble |
| stall | output | 1 | Holds fetch and decode and puts a bubble into execute |
| issue_cnt | output | CW | Instructions passed from decode to execute |
| stall_cnt | output | CW | Stall cycles |
| flush_cnt | output | CW | Squashed fetches |

## Verification
In one cycle a taken branch can ask for a redirect and a flush while a pending source asks for a stall. The bench creates this overlap in two ways. Random stimulus draws register numbers from 0 to 3, so decode sources collide often with execute and memory destinations. Directed cases also set up a taken branch whose source matches the execute destination. The overlap is judged correct when the stall wins with no redirect and no flush in that cycle, and the same branch then redirects and flushes in the first cycle after its producer has moved on.

// File: rtl/branch_hazard_ctrl.sv
module branch_hazard_ctrl #(
  parameter int AW = 32,
  parameter int RW = 5,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          delay_mode,
  input  logic          id_valid,
  input  logic          id_is_branch,
  input  logic          id_taken,
  input  logic [AW-1:0] id_target,
  input  logic          id_use_a,
  input  logic [RW-1:0] id_src_a,
  input  logic          id_use_b,
  input  logic [RW-1:0] id_src_b,
  input  logic          ex_wr_en,
  input  logic [RW-1:0] ex_dst,
  input  logic          mem_load,
  input  logic [RW-1:0] mem_dst,
  output logic          pc_sel,
  output logic [AW-1:0] redirect_pc,
  output logic          ifid_flush,
  output logic          stall,
  output logic [CW-1:0] issue_cnt,
  output logic [CW-1:0] stall_cnt,
  output logic [CW-1:0] flush_cnt
);

  logic br_here, wait_a, wait_b;

  assign br_here = id_valid && id_is_branch;

  assign wait_a = id_use_a && (id_src_a != '0) &&
                  ((ex_wr_en && ex_dst == id_src_a) || (mem_load && mem_dst == id_src_a));
  assign wait_b = id_use_b && (id_src_b != '0) &&
                  ((ex_wr_en && ex_dst == id_src_b) || (mem_load && mem_dst == id_src_b));

  assign stall       = br_here && (wait_a || wait_b);
  assign pc_sel      = br_here && id_taken && !stall;
  assign ifid_flush  = pc_sel && !delay_mode;
  assign redirect_pc = id_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_cnt <= '0;
      stall_cnt <= '0;
      flush_cnt <= '0;
    end else begin
      if (id_valid && !stall) issue_cnt <= issue_cnt + CW'(1);
      if (stall)              stall_cnt <= stall_cnt + CW'(1);
      if (ifid_flush)         flush_cnt <= flush_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/branch_hazard_ctrl_chk.sv
module branch_hazard_ctrl_chk #(
  parameter int RW = 5,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          delay_mode,
  input logic          id_valid,
  input logic          id_is_branch,
  input logic          id_taken,
  input logic          id_use_a,
  input logic [RW-1:0] id_src_a,
  input logic          ex_wr_en,
  input logic [RW-1:0] ex_dst,
  input logic          pc_sel,
  input logic          ifid_flush,
  input logic          stall,
  input logic [CW-1:0] stall_cnt,
  input logic [CW-1:0] flush_cnt
);

  a_r2_not_taken_free: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_is_branch && !id_taken && !stall) |-> (!pc_sel && !ifid_flush));

  a_r3_flush_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> pc_sel);

  a_r4_slot_never_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    delay_mode |-> !ifid_flush);

  a_r5_ex_producer_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_is_branch && id_use_a && id_src_a != '0 && ex_wr_en && ex_dst == id_src_a)
      |-> stall);

  a_r6_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_sel && !ifid_flush));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && id_is_branch) |-> !(stall || pc_sel || ifid_flush));

  a_r8_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> stall_cnt == $past(stall_cnt) + CW'(1));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> $stable(stall_cnt));

  a_r8_flush_count: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |=> flush_cnt == $past(flush_cnt) + CW'(1));

endmodule

bind branch_hazard_ctrl branch_hazard_ctrl_chk #(.RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .delay_mode(delay_mode), .id_valid(id_valid),
  .id_is_branch(id_is_branch), .id_taken(id_taken), .id_use_a(id_use_a),
  .id_src_a(id_src_a), .ex_wr_en(ex_wr_en), .ex_dst(ex_dst), .pc_sel(pc_sel),
  .ifid_flush(ifid_flush), .stall(stall), .stall_cnt(stall_cnt), .flush_cnt(flush_cnt)
);

// File: tb/branch_hazard_ctrl_test.sv
module branch_hazard_ctrl_test;
  localparam int AW = 32, RW = 5, CW = 32;

  logic clk = 0, rst_n = 0;
  logic delay_mode = 0, id_valid = 0, id_is_branch = 0, id_taken = 0;
  logic [AW-1:0] id_target = '0;
  logic id_use_a = 0, id_use_b = 0, ex_wr_en = 0, mem_load = 0;
  logic [RW-1:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0;
  logic pc_sel, ifid_flush, stall;
  logic [AW-1:0] redirect_pc;
  logic [CW-1:0] issue_cnt, stall_cnt, flush_cnt;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_hazard_ctrl #(.AW(AW), .RW(RW), .CW(CW)) uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pend(input logic u, input logic [RW-1:0] r);
    return u && r != 0 && ((ex_wr_en && ex_dst == r) || (mem_load && mem_dst == r));
  endfunction

  function automatic logic [2:0] expect_out();
    logic s, p, f;
    s = id_valid && id_is_branch && (pend(id_use_a, id_src_a) || pend(id_use_b, id_src_b));
    p = id_valid && id_is_branch && id_taken && !s;
    f = p && !delay_mode;
    return {s, p, f};
  endfunction

  task automatic check_outs(input string tag);
    logic [2:0] e;
    e = expect_out();
    chk(stall == e[2], {tag, " stall"}, stall, e[2]);
    chk(pc_sel == e[1], {tag, " pc_sel"}, pc_sel, e[1]);
    chk(ifid_flush == e[0], {tag, " ifid_flush"}, ifid_flush, e[0]);
    if (e[1]) chk(redirect_pc == id_target, {tag, " redirect_pc"}, redirect_pc, id_target);
  endtask

  task automatic quiet();
    id_valid = 0; id_is_branch = 0; id_taken = 0; id_use_a = 0; id_use_b = 0;
    ex_wr_en = 0; mem_load = 0; id_src_a = 0; id_src_b = 0; ex_dst = 0; mem_dst = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); quiet(); rst_n = 0;
    @(negedge clk);
    chk(issue_cnt == 0 && stall_cnt == 0 && flush_cnt == 0, "R1 counters in reset", issue_cnt + stall_cnt + flush_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    chk(issue_cnt == 0 && stall_cnt == 0 && flush_cnt == 0, "R1 counters after reset", issue_cnt + stall_cnt + flush_cnt, 0);
  endtask

  // loop program: 0 load r1, 1 write r2, 2 write r5 from r1/r2, 3 branch on r5 back to 0
  function automatic logic [RW-1:0] dst_of(input int i);
    case (i) 0: return 1; 1: return 2; 2: return 5; default: return 0; endcase
  endfunction

  initial begin
    int e_iss, e_stl, e_fl;
    longint s_iss, s_stl, s_fl;
    int id_i, ex_i, mem_i, pc;
    void'($urandom(32'h5eed));

    do_reset();

    // R2 not taken, zero cost
    @(negedge clk); quiet(); id_valid = 1; id_is_branch = 1; id_taken = 0; id_use_a = 1; id_src_a = 3;
    ex_wr_en = 1; ex_dst = 2; #1;
    chk(!stall && !pc_sel && !ifid_flush, "R2 not-taken no cost", {stall, pc_sel, ifid_flush}, 0);
    // R3 taken, squash mode
    @(negedge clk); id_taken = 1; id_target = 32'h400; #1;
    chk(pc_sel && ifid_flush && redirect_pc == 32'h400, "R3 taken redirect+flush", {pc_sel, ifid_flush}, 3);
    // R4 delay mode
    @(negedge clk); delay_mode = 1; #1;
    chk(pc_sel && !ifid_flush, "R4 delay slot kept", {pc_sel, ifid_flush}, 2);
    delay_mode = 0;
    // R5 register 0 never hazards
    @(negedge clk); id_src_a = 0; ex_dst = 0; ex_wr_en = 1; #1;
    chk(!stall && pc_sel, "R5 r0 no stall", stall, 0);
    // R5 load in mem on source B
    @(negedge clk); ex_wr_en = 0; id_use_b = 1; id_src_b = 7; mem_load = 1; mem_dst = 7; #1;
    chk(stall, "R5 mem load stall", stall, 1);
    // R6 collide taken + hazard, then release
    @(negedge clk); mem_load = 0; id_use_b = 0; id_use_a = 1; id_src_a = 4; ex_wr_en = 1; ex_dst = 4; #1;
    chk(stall && !pc_sel && !ifid_flush, "R6 stall beats flush", {stall, pc_sel, ifid_flush}, 4);
    @(negedge clk); ex_wr_en = 0; #1;
    chk(!stall && pc_sel && ifid_flush, "R6 re-evaluated", {stall, pc_sel, ifid_flush}, 3);
    // R7 non-branch with matching sources
    @(negedge clk); id_is_branch = 0; ex_wr_en = 1; #1;
    chk(!stall && !pc_sel && !ifid_flush, "R7 non-branch quiet", {stall, pc_sel, ifid_flush}, 0);

    // random phase with counter tracking (R8)
    do_reset();
    e_iss = 0; e_stl = 0; e_fl = 0;
    for (int n = 0; n < 600; n++) begin
      logic [2:0] e;
      @(negedge clk);
      delay_mode = ($urandom_range(0, 3) == 0);
      id_valid = $urandom_range(0, 1); id_is_branch = $urandom_range(0, 1); id_taken = $urandom_range(0, 1);
      id_target = $urandom;
      id_use_a = $urandom_range(0, 1); id_src_a = RW'($urandom_range(0, 3));
      id_use_b = $urandom_range(0, 1); id_src_b = RW'($urandom_range(0, 3));
      ex_wr_en = $urandom_range(0, 1); ex_dst = RW'($urandom_range(0, 3));
      mem_load = $urandom_range(0, 1); mem_dst = RW'($urandom_range(0, 3));
      #1;
      check_outs("R5/R6/R7 random");
      e = expect_out();
      if (id_valid && !e[2]) e_iss++;
      if (e[2]) e_stl++;
      if (e[0]) e_fl++;
    end
    @(negedge clk); quiet(); #1;
    chk(issue_cnt == CW'(e_iss), "R8 issue_cnt", issue_cnt, e_iss);
    chk(stall_cnt == CW'(e_stl), "R8 stall_cnt", stall_cnt, e_stl);
    chk(flush_cnt == CW'(e_fl), "R8 flush_cnt", flush_cnt, e_fl);

    // R9 steady taken loop
    do_reset();
    delay_mode = 0;
    id_i = -1; ex_i = -1; mem_i = -1; pc = 0;
    for (int c = 0; c < 12 + 6 * 20; c++) begin
      if (c == 12) begin s_iss = issue_cnt; s_stl = stall_cnt; s_fl = flush_cnt; end
      quiet();
      id_valid = (id_i >= 0); id_is_branch = (id_i == 3); id_taken = 1; id_target = 0;
      id_use_a = 1; id_src_a = 5; id_use_b = 1; id_src_b = 0;
      ex_wr_en = (ex_i >= 0 && ex_i != 3); ex_dst = (ex_i >= 0) ? dst_of(ex_i) : '0;
      mem_load = (mem_i == 0); mem_dst = 1;
      #1;
      mem_i = ex_i;
      if (stall) ex_i = -1;
      else begin
        ex_i = id_i;
        id_i = ifid_flush ? -1 : pc;
        pc = pc_sel ? 0 : (pc + 1) % 4;
      end
      @(negedge clk);
    end
    chk(issue_cnt - s_iss == 80, "R9 issued per 20 loops", issue_cnt - s_iss, 80);
    chk(stall_cnt - s_stl == 20, "R9 stalls per 20 loops", stall_cnt - s_stl, 20);
    chk(flush_cnt - s_fl == 20, "R9 flushes per 20 loops", flush_cnt - s_fl, 20);
    chk((issue_cnt - s_iss) + (stall_cnt - s_stl) + (flush_cnt - s_fl) == 120, "R9 cycles = sum",
        (issue_cnt - s_iss) + (stall_cnt - s_stl) + (flush_cnt - s_fl), 120);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule